// File: doc/BRIEF.md
# Prioritized Grouped Interrupt Controller

This block collects interrupt requests into numbered groups of up to four request bits each. Each group has a 4-bit enable mask and a 3-bit priority level, and software reaches both through a byte-wide register window. Group 0 is the non-maskable group. A request event there, with an enabled request pending, pulses a dedicated output. Group 1 is reserved. Groups 2 and up are maskable. Every cycle they are searched for the pending group with the numerically lowest level, and that level is presented to the processor.

Request events arrive already detected, as one-cycle set pulses from a separate trigger-capture stage. When the processor takes an interrupt, it returns the level it accepted. The controller then latches the group it was presenting into an accepted-group register, which software reads to find the interrupt source. A level returned that does not match the presented level raises an error pulse.

Top module: `grouped_irq_ctrl`

## Requirements
- R1: After synchronous reset every request, enable and level field is 0, `levelOut` is 7, `nmiOut` and `ackErr` are 0, and the accepted-group byte reads 0.
- R2: For a maskable group g (2..30), reading address g*4 returns the raw request bits in [7:4] and request AND enable in [3:0].
- R3: Writing address g*4 of a maskable group uses data [3:0] as a mask and [7:4] as values. Each masked request bit takes the value bit, and each unmasked bit keeps its state.
- R4: Address g*4+1 of groups 0 and 2..30 holds the level in [6:4] and the enable mask in [3:0]. It reads back what was written, with bit 7 as 0.
- R5: Reading address 0 returns group 0's request bits in [2:0] and zeros elsewhere. Writing address 0 clears each request bit whose data bit [3:0] is 1. Set pulses on group 0's input bit 3 are ignored.
- R6: `levelOut` is the lowest level among maskable groups whose request AND enable is nonzero. On a tie, the lower group number wins. It is 7 when none qualifies, and a pending group at level 7 never displaces that default. It reflects register state with one cycle of latency.
- R7: A 1 on `reqSetIn[g*4+i]` sets request bit i of group g at the next edge. If a register write to the same group occurs in the same cycle, the set pulse wins.
- R8: `nmiOut` is high for the cycle after a set pulse on group 0's inputs when, after that update, group 0's request AND enable is nonzero. Otherwise it stays low.
- R9: When `ackValid` is high, the group behind the current `levelOut` is latched as the accepted group. If `ackLevel` differs from `levelOut`, `ackErr` is high in the next cycle.
- R10: Address 0x80 reads the accepted group number shifted left by 2, or 0 if that group's request AND enable is now zero. Other addresses at or above 0x80 read 0.
- R11: Group 1, group index 31, and byte offsets 2 and 3 of every group read 0 and ignore writes. Group 1 set pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqSetIn | input | GROUP_COUNT*4 | Detected request events, bit g*4+i for group g input i |
| busAddr | input | ADDR_W | Register byte address |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 8 | Register write data |
| busRdData | output | 8 | Register read data for busAddr, combinational |
| ackValid | input | 1 | Processor accepts an interrupt |
| ackLevel | input | 3 | Level the processor accepted |
| levelOut | output | 3 | Level of the winning maskable group, 7 when idle |
| nmiOut | output | 1 | Non-maskable interrupt pulse |
| ackErr | output | 1 | Accepted level did not match the presented level |

## Verification
The bound assertions check several properties on every cycle: the post-reset output state, that `levelOut` holds still when no write or request event has occurred, that every `nmiOut` pulse follows a group 0 event, that `ackErr` occurs only after a mismatched acknowledge, and fixed zero fields in the read data. The bench scenarios cover the rest. They sweep all 256 write values on a maskable request byte, compare the selected level and accepted group against a bench model over many request patterns with tied levels, and cover lost requests after acceptance, the set-versus-clear collision, and the reserved regions.

// File: rtl/gic_pkg.sv
package gic_pkg;
  localparam int REQ_W  = 4;
  localparam int LVL_W  = 3;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic       reqWr;
    logic       cfgWr;
    logic       rdGrp;
    logic       accRd;
    logic       ackTake;
    logic       ackBad;
    logic [1:0] byteSel;
  } ctlStrobe_t;
endpackage

// File: rtl/gic_ctrl.sv
module gic_ctrl
  import gic_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int IDX_W = ADDR_W - 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              ackValid,
  input  logic [LVL_W-1:0]  ackLevel,
  input  logic [LVL_W-1:0]  levelOut,
  output ctlStrobe_t        strb,
  output logic [IDX_W-1:0]  grpIdx
);
  logic grpSpace;

  always_comb begin
    grpSpace     = !busAddr[ADDR_W-1];
    grpIdx       = busAddr[ADDR_W-2:2];
    strb.byteSel = busAddr[1:0];
    strb.rdGrp   = grpSpace;
    strb.reqWr   = busWrEn && grpSpace && (busAddr[1:0] == 2'd0);
    strb.cfgWr   = busWrEn && grpSpace && (busAddr[1:0] == 2'd1);
    strb.accRd   = !grpSpace && (busAddr[ADDR_W-2:0] == '0);
    strb.ackTake = ackValid;
    strb.ackBad  = ackValid && (ackLevel != levelOut);
  end
endmodule

// File: rtl/gic_datapath.sv
module gic_datapath
  import gic_pkg::*;
#(
  parameter int GROUP_COUNT = 31,
  parameter int FIRST_LVL   = 2,
  parameter int NMI_INPUTS  = 3,
  parameter int IDX_W       = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  ctlStrobe_t                   strb,
  input  logic [IDX_W-1:0]             grpIdx,
  input  logic [BYTE_W-1:0]            wrData,
  input  logic [GROUP_COUNT*REQ_W-1:0] reqSetIn,
  output logic [BYTE_W-1:0]            rdData,
  output logic [LVL_W-1:0]             levelOut,
  output logic                         nmiOut,
  output logic                         ackErr
);
  localparam logic [LVL_W-1:0] IDLE_LVL = '1;
  localparam int SLOTS = 2 ** IDX_W;

  logic [REQ_W-1:0] req     [GROUP_COUNT];
  logic [REQ_W-1:0] en      [GROUP_COUNT];
  logic [LVL_W-1:0] lvl     [GROUP_COUNT];
  logic [REQ_W-1:0] reqNext [GROUP_COUNT];
  logic [SLOTS-1:0] pendVec;
  logic [REQ_W-1:0] wrVal, wrMask;
  logic [LVL_W-1:0] bestLvl;
  logic [IDX_W-1:0] bestGrp, selGrp, accGrp;
  logic             nmiEvent;

  assign wrVal  = wrData[2*REQ_W-1:REQ_W];
  assign wrMask = wrData[REQ_W-1:0];

  for (genvar g = 0; g < GROUP_COUNT; g++) begin : g_grp
    localparam bit IS_NMI = (g == 0);
    localparam bit IS_LVL = (g >= FIRST_LVL);
    localparam logic [REQ_W-1:0] IN_MASK =
      IS_NMI ? REQ_W'((1 << NMI_INPUTS) - 1) : (IS_LVL ? {REQ_W{1'b1}} : '0);
    logic             hit;
    logic [REQ_W-1:0] setBits, kept;

    assign hit     = (grpIdx == IDX_W'(g));
    assign setBits = reqSetIn[g*REQ_W +: REQ_W] & IN_MASK;

    always_comb begin
      kept = req[g];
      if (strb.reqWr && hit) begin
        if (IS_NMI)      kept = req[g] & ~wrMask;
        else if (IS_LVL) kept = (wrVal & wrMask) | (req[g] & ~wrMask);
      end
      reqNext[g] = kept | setBits;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        req[g] <= '0;
        en[g]  <= '0;
        lvl[g] <= '0;
      end else begin
        req[g] <= reqNext[g];
        if (strb.cfgWr && hit && (IS_NMI || IS_LVL)) begin
          lvl[g] <= wrData[REQ_W +: LVL_W];
          en[g]  <= wrData[REQ_W-1:0];
        end
      end
    end

    assign pendVec[g] = IS_LVL && (|(req[g] & en[g]));
  end

  for (genvar s = GROUP_COUNT; s < SLOTS; s++) begin : g_pad
    assign pendVec[s] = 1'b0;
  end

  assign nmiEvent = (|reqSetIn[NMI_INPUTS-1:0]) && (|(reqNext[0] & en[0]));

  // Ascending scan with strict compare: ties keep the lower group.
  always_comb begin
    bestLvl = IDLE_LVL;
    bestGrp = '0;
    for (int g = FIRST_LVL; g < GROUP_COUNT; g++) begin
      if (pendVec[g] && (lvl[g] < bestLvl)) begin
        bestLvl = lvl[g];
        bestGrp = IDX_W'(g);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      levelOut <= IDLE_LVL;
      selGrp   <= '0;
      accGrp   <= '0;
      ackErr   <= 1'b0;
      nmiOut   <= 1'b0;
    end else begin
      levelOut <= bestLvl;
      selGrp   <= bestGrp;
      ackErr   <= strb.ackBad;
      nmiOut   <= nmiEvent;
      if (strb.ackTake) accGrp <= selGrp;
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.accRd) begin
      if (pendVec[accGrp]) rdData = BYTE_W'({accGrp, 2'b00});
    end else if (strb.rdGrp) begin
      for (int g = 0; g < GROUP_COUNT; g++) begin
        if ((grpIdx == IDX_W'(g)) && ((g == 0) || (g >= FIRST_LVL))) begin
          if (strb.byteSel == 2'd0)
            rdData = (g == 0) ? BYTE_W'(req[g]) : {req[g], req[g] & en[g]};
          else if (strb.byteSel == 2'd1)
            rdData = BYTE_W'({lvl[g], en[g]});
        end
      end
    end
  end
endmodule

// File: rtl/grouped_irq_ctrl.sv
module grouped_irq_ctrl
  import gic_pkg::*;
#(
  parameter int GROUP_COUNT = 31,
  parameter int FIRST_LVL   = 2,
  parameter int NMI_INPUTS  = 3,
  parameter int ADDR_W      = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [GROUP_COUNT*REQ_W-1:0] reqSetIn,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic                         busWrEn,
  input  logic [BYTE_W-1:0]            busWrData,
  output logic [BYTE_W-1:0]            busRdData,
  input  logic                         ackValid,
  input  logic [LVL_W-1:0]             ackLevel,
  output logic [LVL_W-1:0]             levelOut,
  output logic                         nmiOut,
  output logic                         ackErr
);
  localparam int IDX_W = ADDR_W - 3;

  ctlStrobe_t       strb;
  logic [IDX_W-1:0] grpIdx;

  gic_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .ackValid(ackValid),
    .ackLevel(ackLevel),
    .levelOut(levelOut),
    .strb    (strb),
    .grpIdx  (grpIdx)
  );

  gic_datapath #(
    .GROUP_COUNT(GROUP_COUNT),
    .FIRST_LVL  (FIRST_LVL),
    .NMI_INPUTS (NMI_INPUTS),
    .IDX_W      (IDX_W)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .grpIdx  (grpIdx),
    .wrData  (busWrData),
    .reqSetIn(reqSetIn),
    .rdData  (busRdData),
    .levelOut(levelOut),
    .nmiOut  (nmiOut),
    .ackErr  (ackErr)
  );
endmodule

// File: rtl/grouped_irq_ctrl_chk.sv
module grouped_irq_ctrl_chk #(
  parameter int GROUP_COUNT = 31,
  parameter int NMI_INPUTS  = 3,
  parameter int ADDR_W      = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic [GROUP_COUNT*4-1:0] reqSetIn,
  input logic [ADDR_W-1:0]      busAddr,
  input logic                   busWrEn,
  input logic [7:0]             busRdData,
  input logic                   ackValid,
  input logic [2:0]             ackLevel,
  input logic [2:0]             levelOut,
  input logic                   nmiOut,
  input logic                   ackErr
);
  logic [1:0] sinceRst;
  logic       activity;

  assign activity = busWrEn || (|reqSetIn);

  always_ff @(posedge clk) begin
    if (rst) sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  a_r1_reset_outputs: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd0) |-> (levelOut == 3'd7 && !nmiOut && !ackErr));

  a_r6_level_holds: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd3 && !$past(activity) && !$past(activity, 2)) |-> $stable(levelOut));

  a_r8_nmi_needs_event: assert property (@(posedge clk) disable iff (rst)
    nmiOut |-> $past(|reqSetIn[NMI_INPUTS-1:0]));

  a_r9_err_after_mismatch: assert property (@(posedge clk) disable iff (rst)
    ackErr |-> ($past(ackValid) && ($past(ackLevel) != $past(levelOut))));

  a_r5_nmi_read_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (busAddr == '0) |-> (busRdData[7:NMI_INPUTS] == '0));

  a_r4_cfg_bit7_zero: assert property (@(posedge clk) disable iff (rst)
    (!busAddr[ADDR_W-1] && busAddr[1:0] == 2'd1) |-> !busRdData[7]);

  a_r10_accept_aligned: assert property (@(posedge clk) disable iff (rst)
    busAddr[ADDR_W-1] |-> (busRdData[1:0] == 2'b00));
endmodule

bind grouped_irq_ctrl grouped_irq_ctrl_chk #(
  .GROUP_COUNT(GROUP_COUNT),
  .NMI_INPUTS (NMI_INPUTS),
  .ADDR_W     (ADDR_W)
) chk_i (.*);

// File: tb/grouped_irq_ctrl_tb_top.sv
module grouped_irq_ctrl_tb_top;
  localparam int NG = 31;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NG*4-1:0] reqSetIn = '0;
  logic [7:0]    busAddr = '0;
  logic          busWrEn = 1'b0;
  logic [7:0]    busWrData = '0;
  logic [7:0]    busRdData;
  logic          ackValid = 1'b0;
  logic [2:0]    ackLevel = '0;
  logic [2:0]    levelOut;
  logic          nmiOut;
  logic          ackErr;

  int checks = 0;
  int errors = 0;
  int mReq [NG];
  int mEn  [NG];
  int mLvl [NG];
  bit done = 0;

  grouped_irq_ctrl dut_i (.*);

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    busAddr = 8'(a); busWrData = 8'(d); busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdChk(input int a, input int exp, input string tag);
    busAddr = 8'(a);
    #1;
    chk(busRdData == 8'(exp), tag, busRdData, exp);
  endtask

  function automatic int modelGrp();
    int best = 7;
    int grp = 0;
    for (int g = 2; g < NG; g++)
      if (((mReq[g] & mEn[g]) != 0) && mLvl[g] < best) begin
        best = mLvl[g];
        grp = g;
      end
    return grp;
  endfunction

  function automatic int modelLvl();
    int grp = modelGrp();
    return (grp == 0) ? 7 : mLvl[grp];
  endfunction

  task automatic clearAll();
    for (int g = 2; g < NG; g++) begin
      wr(g * 4, 8'h0F);
      mReq[g] = 0;
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cur;
    int exp;
    int v;
    int lv;
    int grp;
    logic [31:0] lfsr = 32'hACE1_2345;
    for (int g = 0; g < NG; g++) begin mReq[g] = 0; mEn[g] = 0; mLvl[g] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk(levelOut == 3'd7, "R1 levelOut", levelOut, 7);
    chk(!nmiOut && !ackErr, "R1 nmi/ackErr", {nmiOut, ackErr}, 0);
    for (int g = 0; g < 32; g++) begin
      rdChk(g * 4, 0, "R1 req byte");
      rdChk(g * 4 + 1, 0, "R1 cfg byte");
    end
    rdChk(8'h80, 0, "R1 accepted");

    // R4 / R11: configuration bytes on every group index
    for (int g = 0; g < 32; g++) begin
      v = (g * 37 + 5) & 8'hFF;
      wr(g * 4 + 1, v);
      if (g == 1 || g == 31) exp = 0;
      else begin
        exp = v & 8'h7F;
        mLvl[g] = (v >> 4) & 7;
        mEn[g] = v & 15;
      end
      rdChk(g * 4 + 1, exp, (g == 1 || g == 31) ? "R11 reserved cfg" : "R4 cfg readback");
    end

    // R3 / R2: full sweep of write values on group 5, two passes
    wr(5 * 4 + 1, 8'h3A);
    mLvl[5] = 3; mEn[5] = 4'hA;
    cur = 0;
    for (int pass = 0; pass < 2; pass++)
      for (int d = 0; d < 256; d++) begin
        v = pass ? (255 - d) : d;
        wr(5 * 4, v);
        cur = (((v >> 4) & (v & 15)) | (cur & ~(v & 15))) & 15;
        rdChk(5 * 4, (cur << 4) | (cur & 4'hA), "R3/R2 set-clear byte");
      end
    wr(5 * 4, 8'h0F);

    // R6 / R9 / R10: priority trials with tied levels
    for (int g = 2; g < NG; g++) begin
      lv = (g * 3) % 8;
      wr(g * 4 + 1, (lv << 4) | 15);
      mLvl[g] = lv; mEn[g] = 15;
    end
    for (int t = 0; t < 60; t++) begin
      logic [NG*4-1:0] pat;
      pat = '0;
      for (int g = 2; g < NG; g++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        if (lfsr[3:0] < 4'd3) begin
          pat[g*4 +: 4] = 4'(1 << lfsr[5:4]);
          mReq[g] = mReq[g] | (1 << lfsr[5:4]);
        end
      end
      reqSetIn = pat;
      @(negedge clk);
      reqSetIn = '0;
      @(negedge clk);
      exp = modelLvl();
      chk(levelOut == 3'(exp), "R6 selected level", levelOut, exp);
      ackValid = 1'b1; ackLevel = 3'(exp);
      @(negedge clk);
      ackValid = 1'b0;
      chk(!ackErr, "R9 matching ack no error", ackErr, 0);
      grp = modelGrp();
      rdChk(8'h80, grp << 2, "R10 accepted group");
      if ((t % 4) == 0 && grp != 0) begin
        wr(grp * 4, 8'h0F);
        mReq[grp] = 0;
        rdChk(8'h80, 0, "R10 lost request reads zero");
      end
      clearAll();
    end

    // R9: mismatched acknowledge
    reqSetIn[7*4 +: 4] = 4'b0010;
    @(negedge clk);
    reqSetIn = '0;
    mReq[7] = 2;
    @(negedge clk);
    exp = modelLvl();
    chk(levelOut == 3'(exp), "R6 single group", levelOut, exp);
    ackValid = 1'b1; ackLevel = 3'(exp) ^ 3'd1;
    @(negedge clk);
    ackValid = 1'b0;
    chk(ackErr, "R9 mismatch flags error", ackErr, 1);
    @(negedge clk);
    chk(!ackErr, "R9 error is one cycle", ackErr, 0);
    rdChk(8'h80, 7 << 2, "R9 mismatched ack still latches");
    wr(7 * 4 + 1, 8'h00);
    mEn[7] = 0;
    rdChk(8'h80, 0, "R10 disabled group reads zero");

    // R7: set pulse wins over a clearing write
    busAddr = 8'(9 * 4); busWrData = 8'h0F; busWrEn = 1'b1;
    reqSetIn[9*4 +: 4] = 4'b0100;
    @(negedge clk);
    busWrEn = 1'b0; reqSetIn = '0;
    rdChk(9 * 4, 8'h44, "R7 set beats clear");
    wr(9 * 4, 8'h0F);

    // R8 / R5: non-maskable group
    wr(1, 8'h00);
    reqSetIn[0] = 1'b1;
    @(negedge clk);
    reqSetIn = '0;
    chk(!nmiOut, "R8 disabled group no pulse", nmiOut, 0);
    rdChk(0, 1, "R5 request captured");
    wr(0, 8'h01);
    rdChk(0, 0, "R5 write-one clears");
    wr(1, 8'h0F);
    reqSetIn[3] = 1'b1;
    @(negedge clk);
    reqSetIn = '0;
    chk(!nmiOut, "R5 input bit 3 ignored", nmiOut, 0);
    rdChk(0, 0, "R5 input bit 3 no request");
    reqSetIn[1] = 1'b1;
    @(negedge clk);
    reqSetIn = '0;
    chk(nmiOut, "R8 pulse on event", nmiOut, 1);
    @(negedge clk);
    chk(!nmiOut, "R8 pulse one cycle", nmiOut, 0);
    rdChk(0, 2, "R5 request bit 1");
    exp = modelLvl();
    chk(levelOut == 3'(exp), "R6 nmi group not in search", levelOut, exp);
    wr(0, 8'hF2);
    rdChk(0, 0, "R5 clear with junk upper bits");

    // R11: reserved regions
    wr(4, 8'hFF);
    rdChk(4, 0, "R11 group 1 req write ignored");
    reqSetIn[1*4 +: 4] = 4'hF;
    @(negedge clk);
    reqSetIn = '0;
    @(negedge clk);
    rdChk(4, 0, "R11 group 1 inputs ignored");
    chk(levelOut == 3'(modelLvl()), "R11 level unchanged", levelOut, modelLvl());
    wr(4 * 4 + 2, 8'hFF);
    rdChk(4 * 4 + 2, 0, "R11 offset 2 reads zero");
    rdChk(4 * 4 + 1, (mLvl[4] << 4) | mEn[4], "R11 neighbour cfg untouched");
    rdChk(8'h81, 0, "R10 other high address zero");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule